// File: doc/BRIEF.md
# Flying-Adder Fractional Clock Synthesizer

This block derives one output clock from a PLL that offers eight evenly spaced phases. Each cycle of the block's single fast clock stands for one phase step, which is one eighth of a PLL period. The block places each synthesized edge a programmable number of phase steps after the previous one. That number has a whole part and a decimal fraction. An integer post-divider then keeps every M-th synthesized edge. The output is a one-cycle pulse on the fast clock at each kept edge, so its rate is the PLL frequency × 8 / (int + frac/10,000,000) / M.

Software programs the block through two write ports. The frequency word holds the integer step in bits 27:24 and the fraction in bits 23:0. Bit 31 is its load strobe. The divider word holds M in bits 7:0 and its load strobe in bit 8. A write takes effect only if its strobe bit is 1 and the value is legal. A legal load restarts the edge train cleanly. An illegal load leaves the active settings as they were and raises an error flag.

A power-down input silences the output. A bypass input routes an external clock straight to the output and ignores the dividers. A build option removes the frequency word, which leaves a fixed-rate output that only M can scale.

Top module: `flyadd_synth`

## Requirements
- R1: After reset, clk_o and err_o are 0 and the active settings are int = RST_INT (8), frac = 0 and M = RST_M (1). The first output pulse appears RST_INT cycles after reset is released.
- R2: With frac = 0 and M = 1, clk_o pulses high for one cycle every int cycles. After a legal load, the first pulse is seen int cycles after the edge that took the load.
- R3: The frac field in bits 23:0 counts in units of 1e-7 of a step. The first interval after a restart is int cycles. At each synthesized edge, frac is added to an accumulator that starts at 0. If the sum reaches 10,000,000, the sum is reduced by 10,000,000 and the next interval is int+1; otherwise the next interval is int.
- R4: phase_o gives the phase index (0 to 7) of the most recent synthesized edge. It is the sum of all intervals since the last restart, modulo 8, and it is 0 after a restart.
- R5: The post-divider M sits in bits 7:0 of the divider word and its load strobe in bit 8. clk_o pulses only on every M-th synthesized edge after a restart.
- R6: A write to either word with its strobe bit at 0 has no effect on the output train.
- R7: A strobed load with int = 0, with frac ≥ 10,000,000, or with M = 0 leaves the active values and the train unchanged and sets err_o to 1 in the next cycle. The next legal strobed load clears err_o.
- R8: While pwd_i is 1, clk_o stays 0. Once pwd_i is 0, the train restarts, and the first pulse comes int cycles after the last edge at which pwd_i was seen high.
- R9: While bypass_i is 1 and pwd_i is 0, clk_o follows byp_clk_i and the dividers play no part. Leaving bypass restarts the train in the same way as R8.
- R10: When HAS_FREQ = 0, writes to the frequency word are ignored and the step stays at RST_INT. Only M scales the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, one cycle per phase step |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_we | input | 1 | Frequency word write enable |
| freq_wdata | input | 32 | Frequency word: strobe 31, int 27:24, frac 23:0 |
| div_we | input | 1 | Divider word write enable |
| div_wdata | input | M_W+1 | Divider word: strobe M_W, M in M_W-1:0 |
| pwd_i | input | 1 | Power-down for this output, 1 = off |
| bypass_i | input | 1 | Bypass request from the parent PLL |
| byp_clk_i | input | 1 | Clock passed through during bypass |
| clk_o | output | 1 | Synthesized output pulse |
| phase_o | output | 3 | Phase index of the latest synthesized edge |
| err_o | output | 1 | Last strobed load was illegal |

## Verification
The bench compares every cycle of clk_o against a model of the edge schedule. It uses a pure integer step, a half fraction that makes the intervals alternate, a quarter fraction combined with M = 3, and a fraction just below one, which produces a carry almost every time. The integer-only train checks the basic count. The fractional trains show whether the carry lands on the right edge. The M = 3 run separates synthesized edges from output pulses. Gap measurements taken after unstrobed and illegal writes show whether any of them disturbed the running train.

// File: rtl/flyadd_synth.sv
module flyadd_synth #(
  parameter int INT_W    = 4,
  parameter int FRAC_W   = 24,
  parameter int M_W      = 8,
  parameter int PH_W     = 3,
  parameter int DEN      = 10_000_000,
  parameter int HAS_FREQ = 1,
  parameter int RST_INT  = 8,
  parameter int RST_M    = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freq_we,
  input  logic [31:0]      freq_wdata,
  input  logic             div_we,
  input  logic [M_W:0]     div_wdata,
  input  logic             pwd_i,
  input  logic             bypass_i,
  input  logic             byp_clk_i,
  output logic             clk_o,
  output logic [PH_W-1:0]  phase_o,
  output logic             err_o
);
  localparam int STEP_W = INT_W + 1;
  localparam int ACC_W  = FRAC_W + 1;

  logic [INT_W-1:0]  int_r;
  logic [FRAC_W-1:0] frac_r;
  logic [M_W-1:0]    m_r, dcnt_r;
  logic [ACC_W-1:0]  acc_r;
  logic [STEP_W-1:0] cnt_r;
  logic [PH_W-1:0]   step_r, phase_r;
  logic              pulse_r, err_r;

  wire [INT_W-1:0]  w_int  = freq_wdata[FRAC_W+INT_W-1:FRAC_W];
  wire [FRAC_W-1:0] w_frac = freq_wdata[FRAC_W-1:0];
  wire [M_W-1:0]    w_m    = div_wdata[M_W-1:0];
  wire spare_unused = ^freq_wdata[30:FRAC_W+INT_W];

  wire ld_f   = (HAS_FREQ != 0) && freq_we && freq_wdata[31];
  wire f_ok   = (w_int != '0) && (32'(w_frac) < 32'(DEN));
  wire ld_m   = div_we && div_wdata[M_W];
  wire m_ok   = w_m != '0;
  wire take_f = ld_f && f_ok;
  wire take_m = ld_m && m_ok;
  wire restart = pwd_i || bypass_i || take_f || take_m;

  wire [INT_W-1:0] nxt_int = take_f ? w_int : int_r;
  wire [ACC_W-1:0] sum     = acc_r + ACC_W'(frac_r);
  wire             carry   = 32'(sum) >= 32'(DEN);
  wire [STEP_W-1:0] nstep  = STEP_W'(int_r) + STEP_W'(carry);
  wire             hit     = cnt_r == STEP_W'(1);
  wire             last_m  = dcnt_r == M_W'(m_r - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_r   <= INT_W'(RST_INT);
      frac_r  <= '0;
      m_r     <= M_W'(RST_M);
      err_r   <= 1'b0;
      acc_r   <= '0;
      cnt_r   <= STEP_W'(RST_INT);
      step_r  <= PH_W'(RST_INT);
      dcnt_r  <= '0;
      phase_r <= '0;
      pulse_r <= 1'b0;
    end else begin
      if (take_f) begin
        int_r  <= w_int;
        frac_r <= w_frac;
      end
      if (take_m) m_r <= w_m;
      if (ld_f || ld_m) err_r <= (ld_f && !f_ok) || (ld_m && !m_ok);
      if (restart) begin
        acc_r   <= '0;
        cnt_r   <= STEP_W'(nxt_int);
        step_r  <= PH_W'(nxt_int);
        dcnt_r  <= '0;
        phase_r <= '0;
        pulse_r <= 1'b0;
      end else if (hit) begin
        acc_r   <= carry ? sum - ACC_W'(DEN) : sum;
        cnt_r   <= nstep;
        step_r  <= PH_W'(nstep);
        phase_r <= phase_r + step_r;
        pulse_r <= last_m;
        dcnt_r  <= last_m ? '0 : dcnt_r + 1'b1;
      end else begin
        cnt_r   <= cnt_r - 1'b1;
        pulse_r <= 1'b0;
      end
    end
  end

  assign clk_o   = pwd_i ? 1'b0 : (bypass_i ? byp_clk_i : pulse_r);
  assign phase_o = phase_r;
  assign err_o   = err_r;
endmodule

// File: rtl/flyadd_synth_chk.sv
module flyadd_synth_chk #(
  parameter int INT_W    = 4,
  parameter int FRAC_W   = 24,
  parameter int M_W      = 8,
  parameter int DEN      = 10_000_000,
  parameter int HAS_FREQ = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              freq_we,
  input logic [31:0]       freq_wdata,
  input logic              div_we,
  input logic [M_W:0]      div_wdata,
  input logic              pwd_i,
  input logic              bypass_i,
  input logic              err_o,
  input logic [INT_W-1:0]  int_r,
  input logic [FRAC_W:0]   acc_r,
  input logic [INT_W:0]    cnt_r,
  input logic [M_W-1:0]    dcnt_r,
  input logic              pulse_r
);
  // R7
  bad_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_FREQ != 0 && freq_we && freq_wdata[31] && freq_wdata[FRAC_W+INT_W-1:FRAC_W] == '0) |=> err_o);

  // R7
  bad_int_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_we && freq_wdata[31] && freq_wdata[FRAC_W+INT_W-1:FRAC_W] == '0) |=> $stable(int_r));

  // R7
  bad_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_we && div_wdata[M_W] && div_wdata[M_W-1:0] == '0) |=> err_o);

  // R8
  pwd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwd_i |=> !pulse_r);

  // R9
  byp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_i |=> (dcnt_r == '0 && acc_r == '0));

  // R3
  acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(acc_r) < 32'(DEN));

  // R2
  cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_r != '0);
endmodule

bind flyadd_synth flyadd_synth_chk #(
  .INT_W(INT_W), .FRAC_W(FRAC_W), .M_W(M_W), .DEN(DEN), .HAS_FREQ(HAS_FREQ)
) u_chk (
  .clk(clk), .rst_n(rst_n), .freq_we(freq_we), .freq_wdata(freq_wdata),
  .div_we(div_we), .div_wdata(div_wdata), .pwd_i(pwd_i), .bypass_i(bypass_i),
  .err_o(err_o), .int_r(int_r), .acc_r(acc_r), .cnt_r(cnt_r),
  .dcnt_r(dcnt_r), .pulse_r(pulse_r)
);

// File: tb/flyadd_synth_tb_top.sv
module flyadd_synth_tb_top;
  localparam int DEN = 10_000_000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic freq_we = 1'b0;
  logic [31:0] freq_wdata = '0;
  logic div_we = 1'b0;
  logic [8:0] div_wdata = '0;
  logic pwd = 1'b0, byp = 1'b0, byp_clk = 1'b0;
  logic clk_o, err_o, clk2, err2;
  logic [2:0] phase_o, ph2;

  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  flyadd_synth dut_i (
    .clk(clk), .rst_n(rst_n), .freq_we(freq_we), .freq_wdata(freq_wdata),
    .div_we(div_we), .div_wdata(div_wdata), .pwd_i(pwd), .bypass_i(byp),
    .byp_clk_i(byp_clk), .clk_o(clk_o), .phase_o(phase_o), .err_o(err_o));

  flyadd_synth #(.HAS_FREQ(0), .RST_INT(2)) fix_i (
    .clk(clk), .rst_n(rst_n), .freq_we(freq_we), .freq_wdata(freq_wdata),
    .div_we(div_we), .div_wdata(div_wdata), .pwd_i(pwd), .bypass_i(byp),
    .byp_clk_i(byp_clk), .clk_o(clk2), .phase_o(ph2), .err_o(err2));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] fword(input bit stb, input int iv, input int fv);
    return {stb, 3'b000, 4'(iv), 24'(fv)};
  endfunction

  task automatic do_load(input logic [31:0] fw, input bit fwe, input logic [8:0] dw, input bit dwe);
    @(negedge clk);
    freq_wdata = fw; freq_we = fwe; div_wdata = dw; div_we = dwe;
    @(posedge clk);
    @(negedge clk);
    freq_we = 1'b0; div_we = 1'b0;
  endtask

  // caller stands at the negedge right after the last restart edge
  task automatic check_train(input int iv, input int fv, input int mv, input int w,
                             input bit use2, input string req);
    int next_e = iv, last = 0, acc = 0, ec = 0, ph = 0, bad_k = -1, got_v = 0, exp_v = 0;
    for (int k = 1; k <= w; k++) begin
      bit e = 0;
      bit g;
      @(negedge clk);
      if (k == next_e) begin
        int stp = iv;
        ec++;
        ph = (ph + next_e - last) % 8;
        last = next_e;
        e = (ec % mv) == 0;
        acc += fv;
        if (acc >= DEN) begin acc -= DEN; stp++; end
        next_e += stp;
      end
      g = use2 ? clk2 : clk_o;
      if (g !== e && bad_k < 0) begin bad_k = k; got_v = g; exp_v = e; end
    end
    check(bad_k < 0, req, got_v, exp_v);
    if (bad_k >= 0) $display("  first mismatch at cycle %0d", bad_k);
    if (!use2) check(phase_o == 3'(ph), {req, " R4 phase"}, phase_o, ph);
  endtask

  task automatic gap_check(input int exp, input string req);
    int n = 0, guard = 0;
    while (clk_o !== 1'b1 && guard < 100) begin @(negedge clk); guard++; end
    @(negedge clk); n = 1;
    while (clk_o !== 1'b1 && n < 100) begin @(negedge clk); n++; end
    check(n == exp, req, n, exp);
  endtask

  task automatic t_reset;
    #1;
    check(clk_o == 1'b0, "R1 clk_o in reset", clk_o, 0);
    check(err_o == 1'b0, "R1 err_o in reset", err_o, 0);
    @(negedge clk); rst_n = 1'b1;
    check_train(8, 0, 1, 40, 0, "R1 default train");
  endtask

  task automatic t_integer;
    do_load(fword(1, 3, 0), 1, 9'h101, 1);
    check_train(3, 0, 1, 30, 0, "R2 int=3");
    do_load(fword(1, 1, 0), 1, 9'h101, 1);
    check_train(1, 0, 1, 12, 0, "R2 int=1");
  endtask

  task automatic t_fraction;
    do_load(fword(1, 2, 5_000_000), 1, 9'h101, 1);
    check_train(2, 5_000_000, 1, 40, 0, "R3 half");
    do_load(fword(1, 1, 9_999_999), 1, 9'h102, 1);
    check_train(1, 9_999_999, 2, 40, 0, "R3 near one");
  endtask

  task automatic t_postdiv;
    do_load(fword(1, 3, 2_500_000), 1, 9'h103, 1);
    check_train(3, 2_500_000, 3, 60, 0, "R5 M=3");
  endtask

  task automatic t_nostrobe;
    do_load(fword(1, 3, 0), 1, 9'h101, 1);
    do_load(fword(0, 5, 0), 1, 9'h004, 1);
    gap_check(3, "R6 unstrobed writes");
  endtask

  task automatic t_illegal;
    do_load(fword(1, 0, 0), 1, 9'h000, 0);
    check(err_o == 1'b1, "R7 int=0 flag", err_o, 1);
    gap_check(3, "R7 int=0 held");
    do_load(fword(0, 0, 0), 0, 9'h101, 1);
    check(err_o == 1'b0, "R7 legal clears", err_o, 0);
    do_load(fword(1, 2, DEN), 1, 9'h000, 0);
    check(err_o == 1'b1, "R7 frac overflow flag", err_o, 1);
    do_load(fword(0, 0, 0), 0, 9'h100, 1);
    check(err_o == 1'b1, "R7 M=0 flag", err_o, 1);
    gap_check(3, "R7 M=0 held");
    do_load(fword(1, 4, 0), 1, 9'h101, 1);
    check(err_o == 1'b0, "R7 legal clears again", err_o, 0);
    check_train(4, 0, 1, 20, 0, "R7 new train");
  endtask

  task automatic t_pwd;
    int hits = 0;
    @(negedge clk); pwd = 1'b1;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (clk_o) hits++; end
    check(hits == 0, "R8 silent", hits, 0);
    pwd = 1'b0;
    check_train(4, 0, 1, 30, 0, "R8 restart");
  endtask

  task automatic t_bypass;
    int miss = 0;
    @(negedge clk); byp = 1'b1;
    for (int i = 0; i < 12; i++) begin
      #2 byp_clk = ~byp_clk;
      #1 if (clk_o !== byp_clk) miss++;
      @(negedge clk);
    end
    check(miss == 0, "R9 passthrough", miss, 0);
    byp_clk = 1'b0;
    byp = 1'b0;
    check_train(4, 0, 1, 30, 0, "R9 restart");
  endtask

  task automatic t_fixed;
    do_load(fword(1, 5, 0), 1, 9'h102, 1);
    check_train(2, 0, 2, 40, 1, "R10 fixed step");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      check(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_integer();
    t_fraction();
    t_postdiv();
    t_nostrobe();
    t_illegal();
    t_pwd();
    t_bypass();
    t_fixed();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule